// File: doc/BRIEF.md
# Latched Interrupt Status and Clear Unit

This block gathers five event sources of a two-wire serial bus controller into latched status bits, one per source, and drives a single interrupt request line from them. Each source is captured on the clock edge where its input is high and the bit stays set until software clears it, whether the input was a one-cycle pulse or a held level. An enable mask chooses which latched bits may reach the interrupt line.

Software reaches the block through a small register port with a write strobe, a write address, write data and a combinational read address and data path. Three registers exist: an enable mask (read and write), a write-one-to-clear register (write only, reads as zero), and a masked status view (read only) that returns the latched bits already ANDed with the mask. The remaining address is unused and reads as zero.

Top module: `irq_status_unit`

## Requirements
- R1: After reset every latched status bit is 0, the enable mask is 0, the masked status reads 0 and `irq_o` is low.
- R2: A 1 on `evt_i[k]` at a clock edge sets latched bit k at that edge, and the bit remains set after the input returns to 0. Bit positions: 0 transfer done, 1 transfer fault, 2 FIFO fault, 3 receive level reached, 4 transmit level reached.
- R3: Writing the mask register (address 0) stores the data; a 1 enables bit k, a 0 disables it; reading address 0 returns the stored mask.
- R4: Reading address 2 returns the latched bits ANDed with the mask; a bit latched while disabled appears as soon as the mask enables it.
- R5: Writing address 1 clears every latched bit whose data bit is 1 and leaves bits whose data bit is 0 unchanged.
- R6: When an event and a clear of the same bit meet at one clock edge, the bit stays set.
- R7: A source input held high keeps its bit set through any number of clears; once it drops, one clear removes the bit.
- R8: `irq_o` is high exactly when the masked status is nonzero.
- R9: Reads of address 1 and address 3 return 0; writes to addresses 2 and 3 change neither the mask nor any latched bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | SRC_N | Event inputs, pulse or level, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | SRC_N | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | SRC_N | Register read data, combinational |
| irq_o | output | 1 | Interrupt request, OR of masked status |

## Verification
A latched bit that fails to set, fails to clear or clears the wrong neighbour shows on the masked status read and on `irq_o` one clock after the offending edge, once its mask bit is on. A corrupted mask shows on the next read of address 0 and as a masked status that hides or reveals the wrong bits. The sweeps cover every mask value against every event pattern and every clear pattern against a full status, so a single wrong bit position or a wrong set/clear priority cannot hide behind a lucky pattern.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int SRC_N  = 5;
  localparam int ADDR_W = 2;

  // register offsets
  localparam int OFS_MASK  = 0;
  localparam int OFS_CLEAR = 1;
  localparam int OFS_MSTAT = 2;

  // source bit positions
  localparam int SRC_DONE    = 0;
  localparam int SRC_XFAULT  = 1;
  localparam int SRC_FFAULT  = 2;
  localparam int SRC_RXLEVEL = 3;
  localparam int SRC_TXLEVEL = 4;

  // next latched value: set wins over clear
  function automatic logic next_bit(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [SRC_N-1:0] masked_view(input logic [SRC_N-1:0] raw,
                                                   input logic [SRC_N-1:0] en);
    return raw & en;
  endfunction
endpackage

// File: rtl/irq_status_bit.sv
module irq_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic raw_o
);
  import irq_unit_pkg::*;

  logic raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= next_bit(raw_q, set_i, clr_i);
  end

  assign raw_o = raw_q;

  // R2 / R6: an event always leaves the bit set, even against a clear
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> raw_o);
  // R5: clear without event drops the bit
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !raw_o);
  // R5: no clear and no event keeps the bit
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(raw_o));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port #(
  parameter int SRC_N  = irq_unit_pkg::SRC_N,
  parameter int ADDR_W = irq_unit_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SRC_N-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [SRC_N-1:0]  raw_i,
  output logic [SRC_N-1:0]  mask_o,
  output logic [SRC_N-1:0]  clr_o,
  output logic [SRC_N-1:0]  mstat_o,
  output logic [SRC_N-1:0]  rd_data_o
);
  import irq_unit_pkg::*;

  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(OFS_MSTAT);

  logic [SRC_N-1:0] mask_q;
  logic             mask_wr;
  logic             clear_wr;

  assign mask_wr  = wr_en_i && (wr_addr_i == A_MASK);
  assign clear_wr = wr_en_i && (wr_addr_i == A_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wr_data_i;
  end

  assign mask_o  = mask_q;
  assign clr_o   = clear_wr ? wr_data_i : '0;
  assign mstat_o = masked_view(raw_i, mask_q);

  always_comb begin
    unique case (rd_addr_i)
      A_MASK:  rd_data_o = mask_q;
      A_MSTAT: rd_data_o = mstat_o;
      default: rd_data_o = '0;
    endcase
  end

  // R3: a mask write lands on the next edge
  assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_o == $past(wr_data_i)));
  // R9: other writes leave the mask alone
  assert_mask_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_o));
  // R9: clear and spare addresses read as zero
  assert_zero_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i != A_MASK && rd_addr_i != A_MSTAT) |-> (rd_data_o == '0));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int SRC_N  = irq_unit_pkg::SRC_N,
  parameter int ADDR_W = irq_unit_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SRC_N-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [SRC_N-1:0]  rd_data_o,
  output logic              irq_o
);
  logic [SRC_N-1:0] raw_w;
  logic [SRC_N-1:0] clr_w;
  logic [SRC_N-1:0] mask_w;
  logic [SRC_N-1:0] mstat_w;

  for (genvar k = 0; k < SRC_N; k++) begin : g_src
    irq_status_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_i[k]),
      .clr_i (clr_w[k]),
      .raw_o (raw_w[k])
    );
  end

  irq_reg_port #(.SRC_N(SRC_N), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .raw_i     (raw_w),
    .mask_o    (mask_w),
    .clr_o     (clr_w),
    .mstat_o   (mstat_w),
    .rd_data_o (rd_data_o)
  );

  assign irq_o = |mstat_w;

  // R8 / R1: a fully disabled mask never raises the line
  assert_mask_gates_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == '0) |-> !irq_o);
  // R8: the line needs at least one latched source
  assert_irq_needs_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (raw_w != '0));
endmodule

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
module irq_status_unit_test;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [N-1:0] rd_data;
  logic         irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // one write, applied at the edge between two falling edges
  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] p);
    @(negedge clk); evt = p;
    @(negedge clk); evt = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  logic [N-1:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); check("R1 mask", v, '0);
    rd(2'd2, v); check("R1 mstat", v, '0);
    check("R1 irq", N'(irq), '0);

    // R2 R3 R4 R8: every mask against every event pattern
    for (int m = 0; m < 32; m++) begin
      for (int p = 0; p < 32; p++) begin
        wr(2'd1, 5'h1f);
        wr(2'd0, N'(m));
        pulse(N'(p));
        rd(2'd2, v); check("R4 mstat", v, N'(m & p));
        check("R8 irq", N'(irq), N'((m & p) != 0));
      end
      rd(2'd0, v); check("R3 mask readback", v, N'(m));
    end

    // R4: latched while disabled, visible on enable
    wr(2'd1, 5'h1f); wr(2'd0, 5'h00);
    pulse(5'b01010);
    rd(2'd2, v); check("R4 hidden", v, '0);
    check("R4 irq hidden", N'(irq), '0);
    wr(2'd0, 5'h1f);
    rd(2'd2, v); check("R2 R4 revealed", v, 5'b01010);

    // R5: every clear pattern against a full status
    for (int c = 0; c < 32; c++) begin
      pulse(5'h1f);
      wr(2'd1, N'(c));
      rd(2'd2, v); check("R5 w1c", v, N'(~c & 31));
      wr(2'd1, 5'h1f);
    end

    // R6: event and clear of the same bit at one edge
    for (int k = 0; k < N; k++) begin
      wr(2'd1, 5'h1f);
      @(negedge clk); evt = N'(1 << k); wr_en = 1'b1; wr_addr = 2'd1; wr_data = 5'h1f;
      @(negedge clk); evt = '0; wr_en = 1'b0;
      rd(2'd2, v); check("R6 set wins", v, N'(1 << k));
    end

    // R7: held level survives clears, then clears once dropped
    wr(2'd1, 5'h1f);
    @(negedge clk); evt = 5'b11100;
    wr(2'd1, 5'h1f);
    rd(2'd2, v); check("R7 held after clear", v, 5'b11100);
    wr(2'd1, 5'h1f);
    rd(2'd2, v); check("R7 held after second clear", v, 5'b11100);
    check("R7 irq held", N'(irq), 5'd1);
    @(negedge clk); evt = '0;
    wr(2'd1, 5'h1f);
    rd(2'd2, v); check("R7 cleared after drop", v, '0);
    check("R8 irq low", N'(irq), '0);

    // R9: ignored writes and zero reads
    wr(2'd0, 5'b00110);
    pulse(5'b10001);
    wr(2'd2, 5'h1f);
    wr(2'd3, 5'h1f);
    rd(2'd0, v); check("R9 mask kept", v, 5'b00110);
    wr(2'd0, 5'h1f);
    rd(2'd2, v); check("R9 status kept", v, 5'b10001);
    rd(2'd1, v); check("R9 clear reads 0", v, '0);
    rd(2'd3, v); check("R9 spare reads 0", v, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule